// File: doc/BRIEF.md
# Transmit Test Pattern Seed Sequencer

This block produces the pseudo-random transmit test pattern for a 66-bit-block physical coding sublayer. While the test enable is high, every block strobe yields one 66-bit block one clock later. In pseudo-random mode, a fixed payload passes through a self-synchronising scrambler with polynomial 1 + x^39 + x^58. The payload is either all zeros or a local-fault control block. Every 128 blocks the scrambler state is overwritten with a programmed seed. The seeds are taken in turn: seed A, the bitwise inverse of A, seed B, the bitwise inverse of B, and then the cycle repeats.

A square-wave mode replaces the scrambled stream with a continuous bit stream of eight ones followed by eight zeros. Each seed is given as a 32-bit low word and a 26-bit high word.

Top module: `tpat_seq`

## Requirements
- R1: While `rst` is high, `blk_vld` and `blk_out` are cleared to zero at every clock edge.
- R2: A strobe sampled with `tx_test_en` high produces exactly one block, with `blk_vld` high in the next cycle only. A strobe sampled with `tx_test_en` low produces no block and leaves `blk_out` unchanged.
- R3: Each 58-bit seed is `{seed_x_hi, seed_x_lo}`: the high word supplies bits 57:32 and the low word supplies bits 31:0.
- R4: The scrambler handles payload bits from bit 0 upward. Each output bit is `in ^ s[38] ^ s[57]`, where `s[0]` is the most recently produced output bit, and that output bit is then shifted in at `s[0]`. Block bits 65:2 carry the scrambled payload.
- R5: In pseudo-random mode, the state is replaced by a seed before the first block and before every 128th block after it. Blocks between reloads continue from the state left by the previous block.
- R6: Successive reloads use seed A, ~A, B and ~B, and then return to A.
- R7: With `zero_sel` = 1 the payload is 64 zero bits, and `blk_out[1:0]` = 2'b10.
- R8: With `zero_sel` = 0 the payload is the control block 64'h0100000001000055 (type byte 0x55 in bits 7:0, with a local-fault sequence set in each half), and `blk_out[1:0]` = 2'b01.
- R9: With `sqw_sel` = 1, bit i of the block is 1 exactly when (phase + i) mod 16 < 8. The phase advances by 66 mod 16 = 2 after each such block. Square-wave blocks leave the reload counter and the seed index unchanged.
- R10: Any cycle with `tx_test_en` low clears the block counter, the seed index and the square-wave phase. The first pseudo-random block after enabling therefore reloads seed A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_test_en | input | 1 | Pattern generation enable |
| zero_sel | input | 1 | 1: zero payload, 0: local-fault payload |
| sqw_sel | input | 1 | 1: square wave, 0: pseudo-random |
| seed_a_lo | input | 32 | Seed A bits 31:0 |
| seed_a_hi | input | 26 | Seed A bits 57:32 |
| seed_b_lo | input | 32 | Seed B bits 31:0 |
| seed_b_hi | input | 26 | Seed B bits 57:32 |
| blk_stb | input | 1 | Request for one block |
| blk_out | output | 66 | Generated block, sync header in bits 1:0 |
| blk_vld | output | 1 | `blk_out` holds a new block |

## Verification
The properties assume that the mode inputs (`zero_sel`, `sqw_sel`) keep the value they had at the strobe edge for the cycle in which they are checked. This is because the header and density checks look back exactly one cycle. The stimulus changes modes and the enable only in cycles with no strobe, just after a clock edge. Seeds are set before the enable rises and are never altered while it is high.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  localparam logic [1:0]  HDR_DATA   = 2'b10;
  localparam logic [1:0]  HDR_CTRL   = 2'b01;
  localparam logic [63:0] LF_PAYLOAD = 64'h0100000001000055;

  typedef enum logic [1:0] {
    SEED_A     = 2'd0,
    SEED_A_INV = 2'd1,
    SEED_B     = 2'd2,
    SEED_B_INV = 2'd3
  } seed_sel_e;
endpackage

// File: rtl/tpat_scrambler.sv
// Unrolled self-synchronising scrambler: one whole payload per call.
module tpat_scrambler #(
  parameter int PAY_W = 64,
  parameter int ST_W  = 58,
  parameter int TAP   = 39
) (
  input  logic [PAY_W-1:0] din,
  input  logic [ST_W-1:0]  st_in,
  output logic [PAY_W-1:0] dout,
  output logic [ST_W-1:0]  st_out
);
  logic [ST_W-1:0]  sh;
  logic [PAY_W-1:0] d;
  logic             b;

  always_comb begin
    sh = st_in;
    d  = '0;
    b  = 1'b0;
    for (int i = 0; i < PAY_W; i++) begin
      b    = din[i] ^ sh[TAP-1] ^ sh[ST_W-1];
      d[i] = b;
      sh   = {sh[ST_W-2:0], b};
    end
    dout   = d;
    st_out = sh;
  end
endmodule

// File: rtl/tpat_seed_mux.sv
module tpat_seed_mux
  import tpat_pkg::*;
#(
  parameter int SEED_W    = 58,
  parameter int SEED_LO_W = 32,
  localparam int SEED_HI_W = SEED_W - SEED_LO_W
) (
  input  seed_sel_e            sel,
  input  logic [SEED_LO_W-1:0] a_lo,
  input  logic [SEED_HI_W-1:0] a_hi,
  input  logic [SEED_LO_W-1:0] b_lo,
  input  logic [SEED_HI_W-1:0] b_hi,
  output logic [SEED_W-1:0]    seed
);
  logic [SEED_W-1:0] sa, sb;
  assign sa = {a_hi, a_lo};
  assign sb = {b_hi, b_lo};

  always_comb begin
    unique case (sel)
      SEED_A:     seed = sa;
      SEED_A_INV: seed = ~sa;
      SEED_B:     seed = sb;
      default:    seed = ~sb;
    endcase
  end
endmodule

// File: rtl/tpat_sqw.sv
// Square wave slice of a continuous stream: HALF ones then HALF zeros.
module tpat_sqw #(
  parameter int BLK_W = 66,
  parameter int HALF  = 8,
  parameter int PH_W  = 4
) (
  input  logic [PH_W-1:0]  phase,
  output logic [BLK_W-1:0] pat
);
  localparam int PER = 2 * HALF;

  always_comb begin
    for (int i = 0; i < BLK_W; i++) begin
      pat[i] = ((int'(phase) + i) % PER) < HALF;
    end
  end
endmodule

// File: rtl/tpat_seq.sv
module tpat_seq
  import tpat_pkg::*;
#(
  parameter int BLK_W       = 66,
  parameter int SEED_W      = 58,
  parameter int SEED_LO_W   = 32,
  parameter int TAP         = 39,
  parameter int RESEED_BLKS = 128,
  parameter int SQW_HALF    = 8,
  localparam int SEED_HI_W  = SEED_W - SEED_LO_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_test_en,
  input  logic                 zero_sel,
  input  logic                 sqw_sel,
  input  logic [SEED_LO_W-1:0] seed_a_lo,
  input  logic [SEED_HI_W-1:0] seed_a_hi,
  input  logic [SEED_LO_W-1:0] seed_b_lo,
  input  logic [SEED_HI_W-1:0] seed_b_hi,
  input  logic                 blk_stb,
  output logic [BLK_W-1:0]     blk_out,
  output logic                 blk_vld
);
  localparam int PAY_W   = BLK_W - 2;
  localparam int CNT_W   = $clog2(RESEED_BLKS);
  localparam int SQW_PER = 2 * SQW_HALF;
  localparam int PH_W    = $clog2(SQW_PER);
  localparam int PH_STEP = BLK_W % SQW_PER;

  logic [SEED_W-1:0] scr_st, st_base, st_next, seed_cur;
  logic [CNT_W-1:0]  blk_cnt;
  seed_sel_e         seed_idx;
  logic [PH_W-1:0]   phase, phase_next;
  logic [PAY_W-1:0]  payload, scr_out;
  logic [BLK_W-1:0]  sqw_pat;
  logic [1:0]        hdr;
  logic              reload;

  tpat_seed_mux #(.SEED_W(SEED_W), .SEED_LO_W(SEED_LO_W)) u_seed (
    .sel(seed_idx), .a_lo(seed_a_lo), .a_hi(seed_a_hi),
    .b_lo(seed_b_lo), .b_hi(seed_b_hi), .seed(seed_cur)
  );

  tpat_scrambler #(.PAY_W(PAY_W), .ST_W(SEED_W), .TAP(TAP)) u_scr (
    .din(payload), .st_in(st_base), .dout(scr_out), .st_out(st_next)
  );

  tpat_sqw #(.BLK_W(BLK_W), .HALF(SQW_HALF), .PH_W(PH_W)) u_sqw (
    .phase(phase), .pat(sqw_pat)
  );

  assign reload  = (blk_cnt == '0);
  assign st_base = reload ? seed_cur : scr_st;
  assign payload = zero_sel ? '0 : PAY_W'(LF_PAYLOAD);
  assign hdr     = zero_sel ? HDR_DATA : HDR_CTRL;

  always_comb begin
    if (int'(phase) + PH_STEP >= SQW_PER)
      phase_next = PH_W'(int'(phase) + PH_STEP - SQW_PER);
    else
      phase_next = PH_W'(int'(phase) + PH_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_st   <= '0;
      blk_cnt  <= '0;
      seed_idx <= SEED_A;
      phase    <= '0;
      blk_out  <= '0;
      blk_vld  <= 1'b0;
    end else begin
      blk_vld <= 1'b0;
      if (!tx_test_en) begin
        blk_cnt  <= '0;
        seed_idx <= SEED_A;
        phase    <= '0;
      end else if (blk_stb) begin
        blk_vld <= 1'b1;
        if (sqw_sel) begin
          blk_out <= sqw_pat;
          phase   <= phase_next;
        end else begin
          blk_out <= {scr_out, hdr};
          scr_st  <= st_next;
          blk_cnt <= (blk_cnt == CNT_W'(RESEED_BLKS - 1)) ? '0 : blk_cnt + 1'b1;
          if (reload) seed_idx <= seed_sel_e'(seed_idx + 2'd1);
        end
      end
    end
  end
endmodule

// File: rtl/tpat_seq_chk.sv
module tpat_seq_chk #(
  parameter int BLK_W    = 66,
  parameter int SQW_HALF = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_test_en,
  input logic             zero_sel,
  input logic             sqw_sel,
  input logic             blk_stb,
  input logic [BLK_W-1:0] blk_out,
  input logic             blk_vld
);
  localparam int PER   = 2 * SQW_HALF;
  localparam int FULL  = (BLK_W / PER) * SQW_HALF;
  localparam int REM   = BLK_W % PER;
  localparam int ONES_LO = FULL + ((REM > SQW_HALF) ? REM - SQW_HALF : 0);
  localparam int ONES_HI = FULL + ((REM < SQW_HALF) ? REM : SQW_HALF);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!blk_vld && blk_out == '0));

  assert_vld_src_R2: assert property (@(posedge clk) disable iff (rst)
    blk_vld |-> $past(blk_stb && tx_test_en));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(blk_stb && tx_test_en)) |-> $stable(blk_out));

  assert_zero_hdr_R7: assert property (@(posedge clk) disable iff (rst)
    (blk_vld && !$past(sqw_sel) && $past(zero_sel)) |-> blk_out[1:0] == 2'b10);

  assert_lf_hdr_R8: assert property (@(posedge clk) disable iff (rst)
    (blk_vld && !$past(sqw_sel) && !$past(zero_sel)) |-> blk_out[1:0] == 2'b01);

  assert_sqw_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (blk_vld && $past(sqw_sel)) |->
      ($countones(blk_out) >= ONES_LO && $countones(blk_out) <= ONES_HI));
endmodule

bind tpat_seq tpat_seq_chk #(.BLK_W(BLK_W), .SQW_HALF(SQW_HALF)) u_chk (
  .clk(clk), .rst(rst), .tx_test_en(tx_test_en), .zero_sel(zero_sel),
  .sqw_sel(sqw_sel), .blk_stb(blk_stb), .blk_out(blk_out), .blk_vld(blk_vld)
);

// File: tb/tpat_seq_test.sv
module tpat_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_test_en = 1'b0, zero_sel = 1'b1, sqw_sel = 1'b0, blk_stb = 1'b0;
  logic [31:0] seed_a_lo = '0, seed_b_lo = '0;
  logic [25:0] seed_a_hi = '0, seed_b_hi = '0;
  logic [65:0] blk_out;
  logic        blk_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [65:0] exp; string tag; } exp_t;
  exp_t q[$];

  logic [57:0] m_st = '0;
  int m_cnt = 0, m_idx = 0, m_ph = 0;

  always #2 clk = ~clk;

  tpat_seq uut (
    .clk(clk), .rst(rst), .tx_test_en(tx_test_en), .zero_sel(zero_sel),
    .sqw_sel(sqw_sel), .seed_a_lo(seed_a_lo), .seed_a_hi(seed_a_hi),
    .seed_b_lo(seed_b_lo), .seed_b_hi(seed_b_hi), .blk_stb(blk_stb),
    .blk_out(blk_out), .blk_vld(blk_vld)
  );

  // R3: seeds assembled as {hi, lo}; R6: order A, ~A, B, ~B
  function automatic logic [57:0] seed_of(int k);
    logic [57:0] a, b;
    a = {seed_a_hi, seed_a_lo};
    b = {seed_b_hi, seed_b_lo};
    case (k)
      0: return a;
      1: return ~a;
      2: return b;
      default: return ~b;
    endcase
  endfunction

  task automatic model_restart();
    m_cnt = 0; m_idx = 0; m_ph = 0;
  endtask

  task automatic strobe(string pre);
    exp_t e;
    logic [57:0] st;
    logic [63:0] pay, o;
    logic        b;
    if (sqw_sel) begin
      for (int i = 0; i < 66; i++) e.exp[i] = ((m_ph + i) % 16) < 8;
      m_ph = (m_ph + 66) % 16;
      e.tag = {pre, " R9"};
    end else begin
      st = (m_cnt == 0) ? seed_of(m_idx) : m_st;
      e.tag = (m_cnt == 0) ? {pre, " R5 R6"} : (zero_sel ? {pre, " R4 R7"} : {pre, " R4 R8"});
      if (m_cnt == 0) m_idx = (m_idx + 1) % 4;
      pay = zero_sel ? 64'h0 : 64'h0100000001000055;
      for (int i = 0; i < 64; i++) begin
        b = pay[i] ^ st[38] ^ st[57];
        o[i] = b;
        st = {st[56:0], b};
      end
      m_st = st;
      m_cnt = (m_cnt + 1) % 128;
      e.exp = {o, zero_sel ? 2'b10 : 2'b01};
    end
    q.push_back(e);
    @(posedge clk); #1 blk_stb = 1'b1;
    @(posedge clk); #1 blk_stb = 1'b0;
  endtask

  // Monitor: compare each produced block with the scoreboard head
  always @(negedge clk) begin
    if (!rst && blk_vld) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected block act=%h exp=none", blk_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (blk_out !== e.exp) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", e.tag, blk_out, e.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=complete");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (blk_vld !== 1'b0 || blk_out !== '0) begin
      n_fail++;
      $display("FAIL R1 act=%b/%h exp=0/0", blk_vld, blk_out);
    end
    @(posedge clk); #1 rst = 1'b0;
    seed_a_lo = 32'h1234_5678; seed_a_hi = 26'h3AB_CDEF;
    seed_b_lo = 32'hDEAD_BEEF; seed_b_hi = 26'h0F0_F0F1;
    @(posedge clk); #1 tx_test_en = 1'b1;

    // R3 R5 R6: zero payload through all four reloads and back to A
    for (int n = 0; n < 520; n++) strobe("R3");
    // R8: local-fault payload mid-interval
    zero_sel = 1'b0;
    for (int n = 0; n < 5; n++) strobe("LF");
    // R9: square wave, phase from zero
    sqw_sel = 1'b1;
    for (int n = 0; n < 10; n++) strobe("SQ");
    // R9: pseudo-random continues where it stopped
    sqw_sel = 1'b0; zero_sel = 1'b1;
    for (int n = 0; n < 3; n++) strobe("RESUME");

    // R2: strobe while disabled is ignored
    tx_test_en = 1'b0;
    model_restart();
    @(posedge clk); #1 blk_stb = 1'b1;
    @(posedge clk); #1 blk_stb = 1'b0;
    @(negedge clk);
    n_chk++;
    if (blk_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 disabled strobe act=%b exp=0", blk_vld);
    end

    // R10: re-enable restarts at seed A; square phase also restarts
    @(posedge clk); #1 tx_test_en = 1'b1;
    for (int n = 0; n < 3; n++) strobe("R10");
    sqw_sel = 1'b1;
    for (int n = 0; n < 2; n++) strobe("R10");
    sqw_sel = 1'b0;

    repeat (4) @(posedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing blocks act=%0d exp=0", q.size());
    end
    finish_run();
  end
endmodule